// File: doc/BRIEF.md
# Microtag Way-Select Cache Lookup

This block is the read lookup path of a four-way set-associative data cache of 16 KB with 32-byte lines and 32-bit byte addresses. Each access is split into a line offset, a set index and a full tag. The low byte of the full tag serves as a short partial tag (the microtag). It is kept in its own array and compared in every way of the indexed set. The way whose microtag matches is the one whose word is driven out. Each way's full tag is compared alongside, and only the full-tag result raises the hit flag.

For the microtag match to pick at most one way, no two valid ways of a set may hold the same microtag. The fill port enforces this when it places a line. If a valid way already carries the incoming microtag, the fill overwrites that way. Otherwise it takes the lowest-numbered invalid way. When the set has neither, it takes the way named by a round-robin pointer kept for each set. Reads are combinational from the address. A fill writes on the rising clock edge.

Top module: `mt_cache_lookup`

## Requirements
- R1: After reset every way of every set is invalid, and any read returns rd_hit = 0.
- R2: A read address splits as byte offset [1:0] (ignored), word select [4:2], set index [11:5] and full tag [31:12]. The microtag is tag bits [7:0], which are address bits [19:12].
- R3: After a fill of tag T into set S, a read of T in S gives rd_hit = 1 and rd_way equal to the filled way. rd_data is word k of the line, where k = address bits [4:2] and word k is line bits [32k+31:32k].
- R4: A fill changes only the set it addresses. The same tag read through another set still misses.
- R5: When a way's microtag matches but its full tag differs, rd_hit = 0 and rd_way still names the microtag-matching way.
- R6: When no valid way of the set matches the microtag, rd_hit = 0.
- R7: A fill whose microtag equals that of a valid way in the set replaces that way. The old tag then misses and the new tag hits in the same way.
- R8: Otherwise a fill takes the lowest-numbered invalid way of the set.
- R9: When all four ways are valid and none shares the microtag, the fill takes the set's round-robin way. This pointer is 0 after reset and advances by one (mod 4) only after such a fill. Each set has its own pointer.
- R10: No set ever holds two valid ways with equal microtags.
- R11: When no microtag matches, rd_way is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 32 | Read byte address |
| rd_data | output | 32 | Selected 32-bit word |
| rd_hit | output | 1 | Full-tag hit |
| rd_way | output | 2 | Way chosen by microtag match |
| fill_en | input | 1 | Write one line this cycle |
| fill_idx | input | 7 | Set index of the fill |
| fill_tag | input | 20 | Full tag of the fill (microtag is its low 8 bits) |
| fill_line | input | 256 | Line contents, word 0 in the low bits |

## Verification
The assertions assume that fill_en, fill_idx and fill_tag are known after reset. They also assume that reset is applied before the first fill, so the valid bits and the round-robin pointers start clean. The stimulus drives every input on the falling clock edge, issues at most one fill per cycle, and samples the combinational read outputs a moment after a falling edge, once each fill has settled. Tags are picked so that the same microtag comes back under a different full tag. This exercises both the alias miss and the replacement of a duplicate microtag.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_WAYS    = 4;
  localparam int unsigned DEF_SETS    = 128;
  localparam int unsigned DEF_LINE_B  = 32;
  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned DEF_UTAG_W  = 8;
endpackage

// File: rtl/mt_tag_store.sv
module mt_tag_store #(
  parameter int unsigned WAYS   = mt_pkg::DEF_WAYS,
  parameter int unsigned SETS   = mt_pkg::DEF_SETS,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned UTAG_W = mt_pkg::DEF_UTAG_W,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic [TAG_W-1:0]       rd_tag,
  output logic [WAYS-1:0]        umatch,
  output logic [WAYS-1:0]        tmatch,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [WAY_W-1:0]       wr_way,
  input  logic [TAG_W-1:0]       wr_tag,
  output logic [WAYS-1:0]        wr_set_valid,
  output logic [WAYS*UTAG_W-1:0] wr_set_utag
);
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   valid_d [SETS];
  logic [TAG_W-1:0]  ftag_q  [WAYS][SETS];
  logic [UTAG_W-1:0] utag_q  [WAYS][SETS];

  always_comb begin
    for (int s = 0; s < SETS; s++) valid_d[s] = valid_q[s];
    if (wr_en) valid_d[wr_idx][wr_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= valid_d[s];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ftag_q[wr_way][wr_idx] <= wr_tag;
      utag_q[wr_way][wr_idx] <= wr_tag[UTAG_W-1:0];
    end
  end

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_cmp
      assign umatch[w] = valid_q[rd_idx][w] && (utag_q[w][rd_idx] == rd_tag[UTAG_W-1:0]);
      assign tmatch[w] = valid_q[rd_idx][w] && (ftag_q[w][rd_idx] == rd_tag);
      assign wr_set_utag[w*UTAG_W +: UTAG_W] = utag_q[w][wr_idx];
    end
  endgenerate
  assign wr_set_valid = valid_q[wr_idx];

  logic dup_any;
  always_comb begin
    dup_any = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int a = 0; a < WAYS; a++)
        for (int b = a + 1; b < WAYS; b++)
          if (valid_q[s][a] && valid_q[s][b] && (utag_q[a][s] == utag_q[b][s]))
            dup_any = 1'b1;
  end

  // R10
  uniq_utag_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_any);
  // R10
  umatch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(umatch));
  // R3
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)][$past(wr_way)]);
endmodule

// File: rtl/mt_victim_sel.sv
module mt_victim_sel #(
  parameter int unsigned WAYS   = mt_pkg::DEF_WAYS,
  parameter int unsigned SETS   = mt_pkg::DEF_SETS,
  parameter int unsigned UTAG_W = mt_pkg::DEF_UTAG_W,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_en,
  input  logic [IDX_W-1:0]       fill_idx,
  input  logic [UTAG_W-1:0]      fill_utag,
  input  logic [WAYS-1:0]        set_valid,
  input  logic [WAYS*UTAG_W-1:0] set_utag,
  output logic [WAY_W-1:0]       victim_way
);
  logic [WAY_W-1:0] rr_q [SETS];
  logic [WAY_W-1:0] rr_d [SETS];
  logic             dup_hit, inv_hit;
  logic [WAY_W-1:0] dup_way, inv_way;

  always_comb begin
    dup_hit = 1'b0;
    inv_hit = 1'b0;
    dup_way = '0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (set_valid[w] && set_utag[w*UTAG_W +: UTAG_W] == fill_utag) begin
        dup_hit = 1'b1;
        dup_way = WAY_W'(w);
      end
      if (!set_valid[w]) begin
        inv_hit = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
    if (dup_hit)      victim_way = dup_way;
    else if (inv_hit) victim_way = inv_way;
    else              victim_way = rr_q[fill_idx];
  end

  always_comb begin
    for (int s = 0; s < SETS; s++) rr_d[s] = rr_q[s];
    if (fill_en && !dup_hit && !inv_hit) rr_d[fill_idx] = rr_q[fill_idx] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= rr_d[s];
    end
  end

  // R8
  empty_set_way0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && set_valid == '0) |-> victim_way == '0);
  // R7
  dup_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && dup_hit) |-> set_valid[victim_way]);
endmodule

// File: rtl/mt_data_store.sv
module mt_data_store #(
  parameter int unsigned WAYS   = mt_pkg::DEF_WAYS,
  parameter int unsigned SETS   = mt_pkg::DEF_SETS,
  parameter int unsigned LINE_W = 8 * mt_pkg::DEF_LINE_B,
  parameter int unsigned WORD_W = mt_pkg::DEF_WORD_W,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned WSEL_W = $clog2(LINE_W / WORD_W)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WSEL_W-1:0] rd_wsel,
  output logic [WORD_W-1:0] rd_word
);
  logic [LINE_W-1:0] line_q [WAYS][SETS];
  logic [LINE_W-1:0] rd_line;

  always_ff @(posedge clk) begin
    if (wr_en) line_q[wr_way][wr_idx] <= wr_line;
  end

  assign rd_line = line_q[rd_way][rd_idx];
  assign rd_word = rd_line[rd_wsel*WORD_W +: WORD_W];
endmodule

// File: rtl/mt_cache_lookup.sv
module mt_cache_lookup #(
  parameter int unsigned ADDR_W = mt_pkg::DEF_ADDR_W,
  parameter int unsigned WAYS   = mt_pkg::DEF_WAYS,
  parameter int unsigned SETS   = mt_pkg::DEF_SETS,
  parameter int unsigned LINE_B = mt_pkg::DEF_LINE_B,
  parameter int unsigned WORD_W = mt_pkg::DEF_WORD_W,
  parameter int unsigned UTAG_W = mt_pkg::DEF_UTAG_W,
  localparam int unsigned OFF_W  = $clog2(LINE_B),
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned LINE_W = 8 * LINE_B,
  localparam int unsigned BYTE_W = $clog2(WORD_W / 8),
  localparam int unsigned WSEL_W = OFF_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_hit,
  output logic [WAY_W-1:0]  rd_way,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line
);
  logic [IDX_W-1:0]       rd_idx;
  logic [TAG_W-1:0]       rd_tag;
  logic [WSEL_W-1:0]      rd_wsel;
  logic [WAYS-1:0]        umatch, tmatch;
  logic [WAYS-1:0]        set_valid;
  logic [WAYS*UTAG_W-1:0] set_utag;
  logic [WAY_W-1:0]       fill_way;

  assign rd_idx  = rd_addr[OFF_W +: IDX_W];
  assign rd_tag  = rd_addr[ADDR_W-1 -: TAG_W];
  assign rd_wsel = rd_addr[BYTE_W +: WSEL_W];

  mt_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .UTAG_W(UTAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_tag(rd_tag), .umatch(umatch), .tmatch(tmatch),
    .wr_en(fill_en), .wr_idx(fill_idx), .wr_way(fill_way), .wr_tag(fill_tag),
    .wr_set_valid(set_valid), .wr_set_utag(set_utag)
  );

  mt_victim_sel #(.WAYS(WAYS), .SETS(SETS), .UTAG_W(UTAG_W)) vsel_i (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_utag(fill_tag[UTAG_W-1:0]), .set_valid(set_valid), .set_utag(set_utag),
    .victim_way(fill_way)
  );

  always_comb begin
    rd_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (umatch[w]) rd_way = WAY_W'(w);
  end

  assign rd_hit = |tmatch;

  mt_data_store #(.WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W), .WORD_W(WORD_W)) data_i (
    .clk(clk), .wr_en(fill_en), .wr_idx(fill_idx), .wr_way(fill_way), .wr_line(fill_line),
    .rd_idx(rd_idx), .rd_way(rd_way), .rd_wsel(rd_wsel), .rd_word(rd_data)
  );

  // R5
  hit_needs_umatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> umatch[rd_way]);
  // R11
  nomatch_way0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (umatch == '0) |-> (rd_way == '0 && !rd_hit));
endmodule

// File: tb/mt_cache_lookup_tb_top.sv
module mt_cache_lookup_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [31:0]  rd_addr;
  logic [31:0]  rd_data;
  logic         rd_hit;
  logic [1:0]   rd_way;
  logic         fill_en;
  logic [6:0]   fill_idx;
  logic [19:0]  fill_tag;
  logic [255:0] fill_line;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mt_cache_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit),
    .rd_way(rd_way), .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_line(fill_line)
  );

  function automatic logic [31:0] wexp(input logic [19:0] t, input logic [6:0] i, input logic [2:0] k);
    return {t[11:0] ^ {5'b0, i}, i, k, t[19:12], 2'b01};
  endfunction

  function automatic logic [31:0] mkaddr(input logic [19:0] t, input logic [6:0] i, input logic [2:0] k);
    return {t, i, k, 2'b10};
  endfunction

  task automatic fill(input logic [19:0] t, input logic [6:0] i);
    @(negedge clk);
    fill_en = 1'b1; fill_idx = i; fill_tag = t;
    for (int k = 0; k < 8; k++) fill_line[k*32 +: 32] = wexp(t, i, 3'(k));
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [19:0] t, input logic [6:0] i, input logic [2:0] k,
                    input logic exp_hit, input logic [1:0] exp_way);
    rd_addr = mkaddr(t, i, k);
    #1;
    total++;
    if (rd_hit !== exp_hit || rd_way !== exp_way) begin
      bad++;
      $display("FAIL %s: tag=%h set=%0d hit/way act=%b/%0d exp=%b/%0d", req, t, i, rd_hit, rd_way, exp_hit, exp_way);
    end
    if (exp_hit) begin
      total++;
      if (rd_data !== wexp(t, i, k)) begin
        bad++;
        $display("FAIL %s: data act=%h exp=%h", req, rd_data, wexp(t, i, k));
      end
    end
  endtask

  task automatic t_reset();
    rd("R1", 20'h12301, 7'd3, 3'd0, 1'b0, 2'd0);
    rd("R1", 20'h00000, 7'd0, 3'd7, 1'b0, 2'd0);
  endtask

  task automatic t_fill_order();
    fill(20'h12301, 7'd3);
    fill(20'h45602, 7'd3);
    fill(20'h78903, 7'd3);
    fill(20'hABC04, 7'd3);
    rd("R8", 20'h12301, 7'd3, 3'd0, 1'b1, 2'd0);
    rd("R3", 20'h45602, 7'd3, 3'd5, 1'b1, 2'd1);
    rd("R8", 20'h78903, 7'd3, 3'd7, 1'b1, 2'd2);
    rd("R2", 20'hABC04, 7'd3, 3'd3, 1'b1, 2'd3);
    rd("R4", 20'h12301, 7'd5, 3'd0, 1'b0, 2'd0);
  endtask

  task automatic t_alias();
    rd("R5", 20'hFFF03, 7'd3, 3'd1, 1'b0, 2'd2);
    rd("R5", 20'h00102, 7'd3, 3'd1, 1'b0, 2'd1);
    rd("R6", 20'h12399, 7'd3, 3'd0, 1'b0, 2'd0);
    rd("R11", 20'h45699, 7'd3, 3'd2, 1'b0, 2'd0);
  endtask

  task automatic t_round_robin();
    fill(20'h11105, 7'd3);
    rd("R9", 20'h11105, 7'd3, 3'd4, 1'b1, 2'd0);
    rd("R9", 20'h12301, 7'd3, 3'd0, 1'b0, 2'd0);
    fill(20'h22206, 7'd3);
    rd("R9", 20'h22206, 7'd3, 3'd6, 1'b1, 2'd1);
  endtask

  task automatic t_dup_replace();
    fill(20'h99903, 7'd3);
    rd("R7", 20'h99903, 7'd3, 3'd2, 1'b1, 2'd2);
    rd("R7", 20'h78903, 7'd3, 3'd2, 1'b0, 2'd2);
    fill(20'h33307, 7'd3);
    rd("R9", 20'h33307, 7'd3, 3'd0, 1'b1, 2'd2);
  endtask

  task automatic t_other_set();
    fill(20'h0A0A1, 7'd127);
    fill(20'h0B0B2, 7'd127);
    fill(20'h0C0C3, 7'd127);
    fill(20'h0D0D4, 7'd127);
    fill(20'h0E0E5, 7'd127);
    rd("R9", 20'h0E0E5, 7'd127, 3'd7, 1'b1, 2'd0);
    rd("R4", 20'h33307, 7'd3, 3'd1, 1'b1, 2'd2);
  endtask

  initial begin
    rst_n = 1'b0; fill_en = 1'b0; fill_idx = '0; fill_tag = '0; fill_line = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_order();
    t_alias();
    t_round_robin();
    t_dup_replace();
    t_other_set();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: act=timeout exp=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule